// File: doc/BRIEF.md
# Packed Pixel to RGB888 Expander

This block sits on the pixel stream that comes after a frame fetch. Each input beat carries one packed pixel of 8 or 16 bits and a depth code that says how to read it. The block also carries the pixel's column and row. It splits the pixel into red, green and blue fields and widens each field to 8 bits by shifting it left. The low bits are filled with zeros, and no bits are copied down into them. It then presents a 24-bit colour, together with the unchanged coordinates, on a registered output.

Both sides use a valid/ready handshake, and there is one register stage between them. The input can accept a beat in every cycle in which the output is empty or is being taken. If a beat carries a depth code that is not supported, the block still consumes it but produces no output beat. Instead it raises an error flag for one cycle.

Top module: `pixel_rgb_expander`

## Requirements
- R1: With depth code 3 (8-bit pixel), the red channel is px[7:5] shifted left by 5, the green channel is px[4:2] shifted left by 5, and the blue channel is px[1:0] shifted left by 6.
- R2: With depth code 4 (16-bit pixel), the red channel is px[14:10] shifted left by 3, the green channel is px[9:5] shifted left by 3, and the blue channel is px[4:0] shifted left by 3.
- R3: Input bits outside the selected layout have no effect on the output colour. These are px[15] in 16-bit mode and px[15:8] in 8-bit mode.
- R4: out_rgb is packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R5: Depth codes 0, 1, 2, 5, 6 and 7 are consumed when in_valid and in_ready are both high, but produce no output beat. out_err is high for exactly the one cycle that follows such a transfer.
- R6: in_ready is high exactly when out_valid is low or out_ready is high.
- R7: A beat accepted on one clock edge appears on the outputs after that edge, so the latency is one cycle. Back-to-back beats flow at one beat per cycle while out_ready is high.
- R8: While out_valid is high and out_ready is low, out_valid, out_rgb, out_x and out_y keep their values.
- R9: out_x and out_y equal the in_x and in_y of the accepted beat.
- R10: While rst is high and after it is released, out_valid and out_err are low until a beat is accepted.
- R11: No bit replication takes place: bits 18:16, 10:8 and 2:0 of out_rgb are always zero whenever out_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_depth | input | 3 | Depth code: 3 = 8-bit, 4 = 16-bit, others are errors |
| in_px | input | 16 | Packed pixel |
| in_x | input | COORD_W | Pixel column |
| in_y | input | COORD_W | Pixel row |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream can take a beat |
| out_rgb | output | 24 | Expanded colour {red, green, blue} |
| out_x | output | COORD_W | Column of the output beat |
| out_y | output | COORD_W | Row of the output beat |
| out_err | output | 1 | One-cycle flag after an unsupported depth was consumed |

## Verification
The assertions check three things on every cycle:
- the output is held under backpressure;
- the error flag only follows a real transfer and never coincides with an output beat;
- each new output beat is preceded by an accepted beat and always carries zero padding bits.

The exact field mapping of every 8-bit and 16-bit code, the handling of the ignored bits and the coordinate pass-through can only be shown by the bench. It sweeps all pixel values in both modes and all six error codes, and it runs a stall-and-release sequence.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
  localparam int PX_W    = 16;
  localparam int DEPTH_W = 3;
  localparam int CH_W    = 8;
  localparam int RGB_W   = 3 * CH_W;

  localparam logic [DEPTH_W-1:0] DEPTH_8BIT  = 3'd3;
  localparam logic [DEPTH_W-1:0] DEPTH_16BIT = 3'd4;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] blue;
  } rgb_t;
endpackage

// File: rtl/pxe_decode.sv
module pxe_decode
  import pxe_pkg::*;
(
  input  logic [PX_W-1:0]    px,
  input  logic [DEPTH_W-1:0] depth,
  output rgb_t               rgb,
  output logic               bad
);
  always_comb begin
    rgb = '0;
    bad = 1'b0;
    case (depth)
      DEPTH_8BIT: begin
        rgb.red   = {px[7:5], 5'b00000};
        rgb.green = {px[4:2], 5'b00000};
        rgb.blue  = {px[1:0], 6'b000000};
      end
      DEPTH_16BIT: begin
        // the mask drops the unused top bit of the 16-bit word
        rgb.red   = CH_W'((px[15:10] & 6'h1F) << 3);
        rgb.green = {px[9:5], 3'b000};
        rgb.blue  = {px[4:0], 3'b000};
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/pxe_stage.sv
module pxe_stage #(
  parameter int W = 46
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_keep,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         dropped
);
  logic valid_q, drop_q;
  logic [W-1:0] data_q;
  logic fire;

  assign in_ready  = !valid_q || out_ready;
  assign fire      = in_valid && in_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign dropped   = drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      drop_q <= fire && !in_keep;
      if (fire)           valid_q <= in_keep;
      else if (out_ready) valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fire && in_keep) data_q <= in_data;
  end

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_one_cycle_latency_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_drop_follows_transfer_R5: assert property (@(posedge clk) disable iff (rst)
    dropped |-> ($past(in_valid && in_ready) && !out_valid));
endmodule

// File: rtl/pixel_rgb_expander.sv
module pixel_rgb_expander
  import pxe_pkg::*;
#(
  parameter int COORD_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_depth,
  input  logic [15:0]        in_px,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [23:0]        out_rgb,
  output logic [COORD_W-1:0] out_x,
  output logic [COORD_W-1:0] out_y,
  output logic               out_err
);
  localparam int PAY_W = RGB_W + 2 * COORD_W;

  rgb_t             dec_rgb;
  logic             dec_bad;
  logic [PAY_W-1:0] pay_in, pay_out;

  pxe_decode u_decode (
    .px    (in_px),
    .depth (in_depth),
    .rgb   (dec_rgb),
    .bad   (dec_bad)
  );

  assign pay_in = {dec_rgb, in_x, in_y};

  pxe_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_keep   (!dec_bad),
    .in_data   (pay_in),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out),
    .dropped   (out_err)
  );

  assign out_rgb = pay_out[PAY_W-1 -: RGB_W];
  assign out_x   = pay_out[2*COORD_W-1 -: COORD_W];
  assign out_y   = pay_out[COORD_W-1:0];

  assert_zero_pad_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_rgb[18:16] == 3'b0 && out_rgb[10:8] == 3'b0 && out_rgb[2:0] == 3'b0));

  assert_err_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (out_err && !(in_valid && in_ready)) |=> !out_err);

  assert_coords_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_x) && $stable(out_y)));
endmodule

// File: tb/pixel_rgb_expander_tb_top.sv
module pixel_rgb_expander_tb_top;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_depth = '0;
  logic [15:0] in_px = '0;
  logic [CW-1:0] in_x = '0, in_y = '0;
  logic out_valid, out_ready = 1'b1, out_err;
  logic [23:0] out_rgb;
  logic [CW-1:0] out_x, out_y;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  pixel_rgb_expander #(.COORD_W(CW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_depth(in_depth), .in_px(in_px), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
    .out_x(out_x), .out_y(out_y), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [2:0] d, input logic [15:0] p);
    int r, g, b;
    if (d == 3'd3) begin
      r = ((p / 32) % 8) * 32; g = ((p / 4) % 8) * 32; b = (p % 4) * 64;
    end else begin
      r = ((p / 1024) % 32) * 8; g = ((p / 32) % 32) * 8; b = (p % 32) * 8;
    end
    return 24'(r * 65536 + g * 256 + b);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // one beat per cycle, checking the previous beat at the next falling edge
  task automatic sweep(input logic [2:0] d, input int n, input string req);
    logic [15:0] pp = '0; logic [CW-1:0] px_x = '0, px_y = '0;
    bit have = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (have) begin
        chk(out_valid, "R7", 32'(out_valid), 1);
        chk(out_rgb == model(d, pp), req, 32'(out_rgb), 32'(model(d, pp)));
        chk(out_x == px_x && out_y == px_y, "R9", {out_x, out_y}, {px_x, px_y});
      end
      pp = (d == 3'd3) ? 16'(((i * 37) % 256) * 256 + (i % 256)) : 16'(i);
      px_x = CW'(i % 2048); px_y = CW'(i / 2048 + 5);
      in_valid = 1; in_depth = d; in_px = pp; in_x = px_x; in_y = px_y;
      have = 1;
    end
    @(negedge clk);
    chk(out_rgb == model(d, pp), req, 32'(out_rgb), 32'(model(d, pp)));
    in_valid = 0;
    @(negedge clk);
    chk(!out_valid, "R7", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_err, "R10", {out_valid, out_err}, 0);
    rst = 0;
    @(negedge clk);
    chk(!out_valid && !out_err && in_ready, "R10", {out_valid, out_err, in_ready}, 1);

    // R1 / R3 / R4: all 8-bit codes with noise in bits 15:8
    sweep(3'd3, 256, "R1_R3_R4");
    // R2 / R3: all 16-bit codes including bit 15 set
    sweep(3'd4, 65536, "R2_R3");

    // R4 explicit packing spot checks
    @(negedge clk); in_valid = 1; in_depth = 3'd4; in_px = 16'h7C00;
    @(negedge clk); in_valid = 0;
    chk(out_rgb == 24'hF80000, "R4", 32'(out_rgb), 32'hF80000);
    @(negedge clk); in_valid = 1; in_depth = 3'd3; in_px = 16'h0003;
    @(negedge clk); in_valid = 0;
    chk(out_rgb == 24'h0000C0, "R4", 32'(out_rgb), 32'h0000C0);

    // R5: unsupported depth codes
    for (int d = 0; d < 8; d++) begin
      if (d == 3 || d == 4) continue;
      @(negedge clk); in_valid = 1; in_depth = 3'(d); in_px = 16'hFFFF;
      @(negedge clk); in_valid = 0;
      chk(out_err && !out_valid, "R5", {out_err, out_valid}, 2);
      @(negedge clk);
      chk(!out_err && !out_valid, "R5", {out_err, out_valid}, 0);
    end
    // R5: bad beat right after a good one clears the output
    @(negedge clk); in_valid = 1; in_depth = 3'd3; in_px = 16'h00FF;
    @(negedge clk); in_depth = 3'd7;
    chk(out_valid, "R7", 32'(out_valid), 1);
    @(negedge clk); in_valid = 0;
    chk(!out_valid && out_err, "R5", {out_valid, out_err}, 1);

    // R6 / R8: backpressure
    @(negedge clk); out_ready = 0;
    chk(in_ready, "R6", 32'(in_ready), 1);
    in_valid = 1; in_depth = 3'd4; in_px = 16'h1234; in_x = 11'd7; in_y = 11'd9;
    @(negedge clk);
    chk(!in_ready, "R6", 32'(in_ready), 0);
    in_px = 16'h4321; in_x = 11'd1; in_y = 11'd2;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_valid && out_rgb == model(3'd4, 16'h1234) && out_x == 7 && out_y == 9,
          "R8", 32'(out_rgb), 32'(model(3'd4, 16'h1234)));
      chk(!in_ready, "R6", 32'(in_ready), 0);
    end
    out_ready = 1; #1;
    chk(in_ready, "R6", 32'(in_ready), 1);
    @(negedge clk); in_valid = 0;
    chk(out_valid && out_rgb == model(3'd4, 16'h4321) && out_x == 1 && out_y == 2,
        "R8", 32'(out_rgb), 32'(model(3'd4, 16'h4321)));
    @(negedge clk);
    chk(!out_valid, "R7", 32'(out_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule